// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen visible general registers of a 32-bit processor together with its current status word and one saved status word for each privileged mode. Some registers exist in several physical copies, and the processor mode picks which copy an index reaches. Fast-interrupt mode has private copies of indices 8 to 14. Interrupt, supervisor, abort and undefined modes have private copies of indices 13 and 14 only. User and system mode use the common bank. Indices 0 to 7 and 15 are the same in every mode.

The core reads two registers combinationally and writes one per clock. It can change mode through a request input, or take an exception. An exception moves the current status into the target mode's saved status, sets the interrupt-disable bit, switches mode and loads the target's link register (index 14) with a return address, all on one clock edge. The mode is the state of the block. Its states are user (`10000`), fast-interrupt (`10001`), interrupt (`10010`), supervisor (`10011`), abort (`10111`), undefined (`11011`) and system (`11111`). There are three transitions: the reset entry into supervisor, the mode-request move, and the exception-entry move. Both moves can reach any state from any state.

Top module: `mode_bank_regfile`

## Requirements
- R1: After reset the current status reads `0x000000D3`: supervisor mode, interrupt-disable (bit 7) and fast-interrupt-disable (bit 6) set, flags clear. Every register reads zero.
- R2: Any mode written by a request or a saved-status write has bit 4 of the mode forced to one. For example, a request for `00010` gives `10010`.
- R3: User mode (`10000`) and system mode (`11111`) reach the same copy of every register.
- R4: In fast-interrupt mode (`10001`) indices 8 to 14 reach private copies. A write there leaves the user copies unchanged.
- R5: Interrupt (`10010`), supervisor (`10011`), abort (`10111`) and undefined (`11011`) modes each have private copies of indices 13 and 14. Indices 8 to 12 reach the user copies.
- R6: Indices 0 to 7 and index 15 reach one shared copy in all modes.
- R7: In user or system mode the saved-status output equals the current status.
- R8: A saved-status write in user or system mode changes no status word.
- R9: On exception entry, on the next edge: the target's saved status holds the old current status; the mode equals the target; bit 7 is set; the flags and bit 6 are unchanged; and the target's index 14 holds the return address.
- R10: An exception wins over a register write, a mode request and a status write in the same cycle. Those other requests are dropped.
- R11: A mode request takes effect on the next edge. A request for the mode already in force changes nothing.
- R12: A write to a banked index updates only the copy that belongs to the current mode.
- R13: A current-status write updates only bits 31:28 (flags) and bits 7:6 (disable bits). A saved-status write stores the flags, the disable bits and the mode (with R2 applied). The status layout is: flags in 31:28, disable bits in 7:6, mode in 4:0, all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | DATA_W | Read port A data (combinational) |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | DATA_W | Read port B data (combinational) |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | DATA_W | Register write data |
| mode_req | input | 1 | Mode-change request |
| mode_req_val | input | 5 | Requested mode |
| exc_en | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Exception target mode |
| exc_ret | input | DATA_W | Return address written to the target's index 14 |
| status_wr_en | input | 1 | Status write enable |
| status_wr_saved | input | 1 | 1 selects the saved status, 0 the current status |
| status_wr_data | input | 32 | Status write data |
| cur_status | output | 32 | Current status word |
| saved_status | output | 32 | Saved status of the current mode |

## Verification
The bench fills each bank with its own distinct values and then reads them back from every mode. This tells a wrong bank mapping apart from a missing private copy. The user and system pair checks that the two modes alias fully, and the fast-interrupt pass checks that indices 8 to 12 are private only there. The exception cases start from a status word with nonzero flags and the disable bits clear, so the saved copy, the forced bit 7 and the untouched bit 6 are each visible on their own. A final case raises every request in the same cycle as an exception to show that the exception has priority.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

    localparam int NUM_REGS       = 16;
    localparam int FIQ_FIRST      = 8;
    localparam int PRIV_FIRST     = 13;
    localparam int NUM_PRIV_BANKS = 4;
    localparam int FIQ_CNT        = NUM_REGS - 1 - FIQ_FIRST;
    localparam int PRIV_CNT       = NUM_REGS - 1 - PRIV_FIRST;
    localparam int USR_BASE       = FIQ_FIRST;
    localparam int FIQ_BASE       = USR_BASE + FIQ_CNT;
    localparam int PRIV_BASE      = FIQ_BASE + FIQ_CNT;
    localparam int PC_SLOT        = PRIV_BASE + NUM_PRIV_BANKS * PRIV_CNT;
    localparam int NUM_SLOTS      = PC_SLOT + 1;
    localparam int SLOT_W         = $clog2(NUM_SLOTS);
    localparam int IDX_W          = $clog2(NUM_REGS);
    localparam int NUM_SAVED      = NUM_PRIV_BANKS + 1;
    localparam int LINK_IDX       = NUM_REGS - 2;

    typedef enum logic [4:0] {
        MODE_USR = 5'h10,
        MODE_FIQ = 5'h11,
        MODE_IRQ = 5'h12,
        MODE_SVC = 5'h13,
        MODE_ABT = 5'h17,
        MODE_UND = 5'h1B,
        MODE_SYS = 5'h1F
    } mode_e;

    // Bank order matters: privileged banks follow BANK_IRQ contiguously.
    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    typedef struct packed {
        logic  n;
        logic  z;
        logic  c;
        logic  v;
        logic  i;
        logic  f;
        mode_e mode;
    } status_t;

    function automatic bank_e bank_of(input logic [4:0] m);
        case (m)
            MODE_FIQ: return BANK_FIQ;
            MODE_IRQ: return BANK_IRQ;
            MODE_SVC: return BANK_SVC;
            MODE_ABT: return BANK_ABT;
            MODE_UND: return BANK_UND;
            default:  return BANK_USR;
        endcase
    endfunction

    function automatic logic [31:0] to_word(input status_t s);
        return {s.n, s.z, s.c, s.v, 20'd0, s.i, s.f, 1'b0, s.mode};
    endfunction

    function automatic status_t from_word(input logic [31:0] w);
        status_t s;
        s.n    = w[31];
        s.z    = w[30];
        s.c    = w[29];
        s.v    = w[28];
        s.i    = w[7];
        s.f    = w[6];
        s.mode = mode_e'(w[4:0] | 5'h10);
        return s;
    endfunction

endpackage

// File: rtl/mbrf_slot_map.sv
module mbrf_slot_map
    import mbrf_pkg::*;
(
    input  bank_e              bank,
    input  logic [IDX_W-1:0]   idx,
    output logic [SLOT_W-1:0]  slot
);

    always_comb begin
        int r;
        int s;
        r = int'(idx);
        if (r < FIQ_FIRST) begin
            s = r;
        end else if (r == NUM_REGS - 1) begin
            s = PC_SLOT;
        end else if (bank == BANK_FIQ) begin
            s = FIQ_BASE + r - FIQ_FIRST;
        end else if (bank != BANK_USR && r >= PRIV_FIRST) begin
            s = PRIV_BASE + (int'(bank) - int'(BANK_IRQ)) * PRIV_CNT + r - PRIV_FIRST;
        end else begin
            s = USR_BASE + r - FIQ_FIRST;
        end
        slot = SLOT_W'(s);
    end

endmodule

// File: rtl/mbrf_storage.sv
module mbrf_storage
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [SLOT_W-1:0]   wslot,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                lk_we,
    input  logic [SLOT_W-1:0]   lk_slot,
    input  logic [DATA_W-1:0]   lk_data,
    input  logic [SLOT_W-1:0]   ra_slot,
    input  logic [SLOT_W-1:0]   rb_slot,
    output logic [DATA_W-1:0]   ra_data,
    output logic [DATA_W-1:0]   rb_data
);

    logic [DATA_W-1:0] mem [NUM_SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_SLOTS; g++) begin
                mem[g] <= '0;
            end
        end else begin
            for (int g = 0; g < NUM_SLOTS; g++) begin
                if (lk_we && lk_slot == SLOT_W'(g)) begin
                    mem[g] <= lk_data;
                end else if (we && wslot == SLOT_W'(g)) begin
                    mem[g] <= wdata;
                end
            end
        end
    end

    assign ra_data = mem[ra_slot];
    assign rb_data = mem[rb_slot];

endmodule

// File: rtl/mbrf_status.sv
module mbrf_status
    import mbrf_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exc_en,
    input  logic [4:0]   exc_mode,
    input  logic         mode_req,
    input  logic [4:0]   mode_req_val,
    input  logic         st_we,
    input  logic         st_saved,
    input  logic [31:0]  st_wdata,
    output logic [31:0]  cur_word,
    output logic [31:0]  saved_word,
    output bank_e        cur_bank,
    output bank_e        exc_bank
);

    status_t cur_q, cur_d;
    status_t saved_q [NUM_SAVED];
    status_t saved_d [NUM_SAVED];
    status_t wr_st;
    logic    unused_bits;

    assign unused_bits = ^{st_wdata[27:8], st_wdata[5]};
    assign wr_st       = from_word(st_wdata);
    assign cur_bank    = bank_of(cur_q.mode);
    assign exc_bank    = bank_of(exc_mode | 5'h10);

    // Next-state: exception move, request move, or field updates.
    always_comb begin
        cur_d   = cur_q;
        saved_d = saved_q;
        if (exc_en) begin
            if (exc_bank != BANK_USR) begin
                saved_d[int'(exc_bank) - 1] = cur_q;
            end
            cur_d.mode = mode_e'(exc_mode | 5'h10);
            cur_d.i    = 1'b1;
        end else begin
            if (mode_req) begin
                cur_d.mode = mode_e'(mode_req_val | 5'h10);
            end
            if (st_we && !st_saved) begin
                cur_d.n = wr_st.n;
                cur_d.z = wr_st.z;
                cur_d.c = wr_st.c;
                cur_d.v = wr_st.v;
                cur_d.i = wr_st.i;
                cur_d.f = wr_st.f;
            end
            if (st_we && st_saved && cur_bank != BANK_USR) begin
                saved_d[int'(cur_bank) - 1] = wr_st;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0,
                       i: 1'b1, f: 1'b1, mode: MODE_SVC};
            for (int k = 0; k < NUM_SAVED; k++) begin
                saved_q[k] <= '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0,
                               i: 1'b0, f: 1'b0, mode: mode_e'(5'h00)};
            end
        end else begin
            cur_q <= cur_d;
            for (int k = 0; k < NUM_SAVED; k++) begin
                saved_q[k] <= saved_d[k];
            end
        end
    end

    // Outputs.
    always_comb begin
        cur_word = to_word(cur_q);
        unique case (cur_bank)
            BANK_USR: saved_word = cur_word;
            BANK_FIQ: saved_word = to_word(saved_q[0]);
            BANK_IRQ: saved_word = to_word(saved_q[1]);
            BANK_SVC: saved_word = to_word(saved_q[2]);
            BANK_ABT: saved_word = to_word(saved_q[3]);
            BANK_UND: saved_word = to_word(saved_q[4]);
            default:  saved_word = cur_word;
        endcase
    end

endmodule

// File: rtl/mode_bank_regfile.sv
module mode_bank_regfile
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         rd_a_idx,
    output logic [DATA_W-1:0]  rd_a_data,
    input  logic [3:0]         rd_b_idx,
    output logic [DATA_W-1:0]  rd_b_data,
    input  logic               wr_en,
    input  logic [3:0]         wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               mode_req,
    input  logic [4:0]         mode_req_val,
    input  logic               exc_en,
    input  logic [4:0]         exc_mode,
    input  logic [DATA_W-1:0]  exc_ret,
    input  logic               status_wr_en,
    input  logic               status_wr_saved,
    input  logic [31:0]        status_wr_data,
    output logic [31:0]        cur_status,
    output logic [31:0]        saved_status
);

    localparam int NUM_MAPS = 4;

    bank_e              cur_bank, exc_bank;
    bank_e              map_bank [NUM_MAPS];
    logic [IDX_W-1:0]   map_idx  [NUM_MAPS];
    logic [SLOT_W-1:0]  map_slot [NUM_MAPS];

    mbrf_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .exc_en       (exc_en),
        .exc_mode     (exc_mode),
        .mode_req     (mode_req),
        .mode_req_val (mode_req_val),
        .st_we        (status_wr_en),
        .st_saved     (status_wr_saved),
        .st_wdata     (status_wr_data),
        .cur_word     (cur_status),
        .saved_word   (saved_status),
        .cur_bank     (cur_bank),
        .exc_bank     (exc_bank)
    );

    // Map 0/1: read ports, 2: write port, 3: exception link register.
    assign map_bank[0] = cur_bank;
    assign map_idx[0]  = rd_a_idx;
    assign map_bank[1] = cur_bank;
    assign map_idx[1]  = rd_b_idx;
    assign map_bank[2] = cur_bank;
    assign map_idx[2]  = wr_idx;
    assign map_bank[3] = exc_bank;
    assign map_idx[3]  = IDX_W'(LINK_IDX);

    for (genvar m = 0; m < NUM_MAPS; m++) begin : g_map
        mbrf_slot_map u_map (
            .bank (map_bank[m]),
            .idx  (map_idx[m]),
            .slot (map_slot[m])
        );
    end

    mbrf_storage #(.DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en && !exc_en),
        .wslot   (map_slot[2]),
        .wdata   (wr_data),
        .lk_we   (exc_en),
        .lk_slot (map_slot[3]),
        .lk_data (exc_ret),
        .ra_slot (map_slot[0]),
        .rb_slot (map_slot[1]),
        .ra_data (rd_a_data),
        .rb_data (rd_b_data)
    );

endmodule

// File: rtl/mbrf_checker.sv
module mbrf_checker
    import mbrf_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         exc_en,
    input logic [4:0]   exc_mode,
    input logic         mode_req,
    input logic [4:0]   mode_req_val,
    input logic         status_wr_en,
    input logic         status_wr_saved,
    input logic [31:0]  status_wr_data,
    input logic [31:0]  cur_status,
    input logic [31:0]  saved_status
);

    assert_req_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req && !exc_en) |=> cur_status[4:0] == ($past(mode_req_val) | 5'h10));

    assert_sys_saved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_of(cur_status[4:0]) == BANK_USR) |-> saved_status == cur_status);

    assert_exc_saved_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && bank_of(exc_mode | 5'h10) != BANK_USR) |=> saved_status == $past(cur_status));

    assert_exc_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_en |=> (cur_status[7] && cur_status[4:0] == ($past(exc_mode) | 5'h10)
                    && cur_status[6] == $past(cur_status[6])));

    assert_exc_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_en |=> cur_status[31:28] == $past(cur_status[31:28]));

    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_en && !mode_req) |=> cur_status[4:0] == $past(cur_status[4:0]));

    assert_flag_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (status_wr_en && !status_wr_saved && !exc_en)
        |=> cur_status[31:28] == $past(status_wr_data[31:28]));

endmodule

bind mode_bank_regfile mbrf_checker u_mbrf_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .exc_en          (exc_en),
    .exc_mode        (exc_mode),
    .mode_req        (mode_req),
    .mode_req_val    (mode_req_val),
    .status_wr_en    (status_wr_en),
    .status_wr_saved (status_wr_saved),
    .status_wr_data  (status_wr_data),
    .cur_status      (cur_status),
    .saved_status    (saved_status)
);

// File: tb/tb_mode_bank_regfile.sv
module tb_mode_bank_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, exc_ret = '0;
    logic        wr_en = 0, mode_req = 0, exc_en = 0;
    logic        status_wr_en = 0, status_wr_saved = 0;
    logic [4:0]  mode_req_val = '0, exc_mode = '0;
    logic [31:0] status_wr_data = '0, cur_status, saved_status;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mode_bank_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .mode_req(mode_req), .mode_req_val(mode_req_val),
        .exc_en(exc_en), .exc_mode(exc_mode), .exc_ret(exc_ret),
        .status_wr_en(status_wr_en), .status_wr_saved(status_wr_saved),
        .status_wr_data(status_wr_data),
        .cur_status(cur_status), .saved_status(saved_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int idx, input logic [31:0] v);
        wr_en = 1; wr_idx = 4'(idx); wr_data = v;
        tick();
        wr_en = 0;
    endtask

    task automatic go_mode(input logic [4:0] m);
        mode_req = 1; mode_req_val = m;
        tick();
        mode_req = 0;
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        rd_a_idx = 4'(idx);
        #1;
        v = rd_a_data;
    endtask

    task automatic rd_b(input int idx, output logic [31:0] v);
        rd_b_idx = 4'(idx);
        #1;
        v = rd_b_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 status", cur_status, 32'h0000_00D3);
        for (int i = 0; i < 16; i++) begin
            rd(i, v);
            check("R1 reg", v, 32'h0);
        end
    endtask

    task automatic t_common();
        logic [31:0] v;
        wr(0, 32'h0000_1000); wr(7, 32'h0000_7007); wr(15, 32'h0000_F00F);
        go_mode(5'h10);
        rd(0, v);   check("R6 r0",  v, 32'h0000_1000);
        rd_b(7, v); check("R6 r7",  v, 32'h0000_7007);
        rd(15, v);  check("R6 r15", v, 32'h0000_F00F);
        go_mode(5'h11);
        rd_b(15, v); check("R6 r15 fiq", v, 32'h0000_F00F);
    endtask

    task automatic t_usr_sys();
        logic [31:0] v;
        go_mode(5'h10);
        for (int i = 8; i < 15; i++) wr(i, 32'h0000_0800 + 32'(i));
        go_mode(5'h1F);
        for (int i = 8; i < 15; i++) begin
            rd(i, v);
            check("R3 sys alias", v, 32'h0000_0800 + 32'(i));
        end
        check("R7 sys saved", saved_status, cur_status);
    endtask

    task automatic t_fiq();
        logic [31:0] v;
        go_mode(5'h11);
        for (int i = 8; i < 15; i++) begin
            rd(i, v);
            check("R4 fiq fresh", v, 32'h0);
        end
        for (int i = 8; i < 15; i++) wr(i, 32'h0000_F800 + 32'(i));
        rd(9, v); check("R4 fiq private", v, 32'h0000_F809);
        go_mode(5'h10);
        for (int i = 8; i < 15; i++) begin
            rd(i, v);
            check("R4 user kept", v, 32'h0000_0800 + 32'(i));
        end
    endtask

    task automatic t_priv();
        logic [31:0] v;
        logic [4:0] md [4] = '{5'h12, 5'h13, 5'h17, 5'h1B};
        for (int k = 0; k < 4; k++) begin
            go_mode(md[k]);
            rd(8, v);  check("R5 shared r8", v, 32'h0000_0808);
            rd(12, v); check("R5 shared r12", v, 32'h0000_080C);
            wr(13, 32'h1300_0000 | 32'(k));
            wr(14, 32'h1400_0000 | 32'(k));
        end
        for (int k = 0; k < 4; k++) begin
            go_mode(md[k]);
            rd(13, v);   check("R12 own r13", v, 32'h1300_0000 | 32'(k));
            rd_b(14, v); check("R12 own r14", v, 32'h1400_0000 | 32'(k));
        end
        go_mode(5'h10);
        rd(13, v); check("R12 user r13", v, 32'h0000_080D);
        rd(14, v); check("R12 user r14", v, 32'h0000_080E);
    endtask

    task automatic t_force_top();
        go_mode(5'h02);
        check("R2 forced bit", {27'd0, cur_status[4:0]}, 32'h12);
    endtask

    task automatic t_same_mode();
        logic [31:0] v;
        logic [31:0] st;
        st = cur_status;
        go_mode(5'h12);
        check("R11 status same", cur_status, st);
        rd(13, v); check("R11 r13 same", v, 32'h1300_0000);
        go_mode(5'h13);
        check("R11 next edge", {27'd0, cur_status[4:0]}, 32'h13);
    endtask

    task automatic t_saved_user();
        go_mode(5'h10);
        check("R7 user saved", saved_status, 32'h0000_00D0);
        status_wr_en = 1; status_wr_saved = 1; status_wr_data = 32'hF000_001B;
        tick();
        status_wr_en = 0; status_wr_saved = 0;
        check("R8 cur kept", cur_status, 32'h0000_00D0);
        check("R8 saved view", saved_status, 32'h0000_00D0);
        go_mode(5'h12);
        check("R8 irq saved kept", saved_status, 32'h0);
    endtask

    task automatic t_status_write();
        go_mode(5'h13);
        status_wr_en = 1; status_wr_saved = 0; status_wr_data = 32'hF000_00FF;
        tick();
        check("R13 cur write", cur_status, 32'hF000_00D3);
        status_wr_data = 32'h5000_0000;
        tick();
        check("R13 cur clear", cur_status, 32'h5000_0013);
        status_wr_saved = 1; status_wr_data = 32'h6FFF_FF40;
        tick();
        status_wr_en = 0; status_wr_saved = 0;
        check("R13 saved write", saved_status, 32'h6000_0050);
        check("R13 cur untouched", cur_status, 32'h5000_0013);
    endtask

    task automatic t_exception();
        logic [31:0] v;
        exc_en = 1; exc_mode = 5'h1B; exc_ret = 32'h1234_5678;
        tick();
        exc_en = 0;
        check("R9 cur", cur_status, 32'h5000_009B);
        check("R9 saved", saved_status, 32'h5000_0013);
        rd(14, v); check("R9 link", v, 32'h1234_5678);
        rd(13, v); check("R9 r13 kept", v, 32'h1300_0003);
    endtask

    task automatic t_exc_priority();
        logic [31:0] v;
        exc_en = 1; exc_mode = 5'h12; exc_ret = 32'hCAFE_0004;
        wr_en = 1; wr_idx = 4'd0; wr_data = 32'hDEAD_BEEF;
        mode_req = 1; mode_req_val = 5'h11;
        status_wr_en = 1; status_wr_saved = 0; status_wr_data = 32'h0;
        tick();
        exc_en = 0; wr_en = 0; mode_req = 0; status_wr_en = 0;
        check("R10 cur", cur_status, 32'h5000_0092);
        check("R10 saved", saved_status, 32'h5000_009B);
        rd(0, v);  check("R10 r0 kept", v, 32'h0000_1000);
        rd(14, v); check("R10 link", v, 32'hCAFE_0004);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #12;
        rst_n = 1;
        #1;
        @(negedge clk);
        t_reset();
        t_common();
        t_usr_sys();
        t_fiq();
        t_priv();
        t_force_top();
        t_same_mode();
        t_saved_user();
        t_status_write();
        t_exception();
        t_exc_priority();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule